// File: doc/BRIEF.md
# UART Interrupt Cause and Status Word

This block gathers the interrupt sources of a UART into one 32-bit status word and drives a single level interrupt line. It watches five sources: a line-status event, a receive-data event, a receive character-timeout event, a transmit-space event, and a change on any modem input line. Each source has its own sticky cause bit. A cause bit is set only while the matching enable input allows it. Any mix of cause bits can be set at once. Software clears cause bits by writing a byte whose set bits name the causes to drop.

The same word also shows other state. It carries the registered modem input levels and a sticky per-line change flag for each modem line. It also passes through the receive fill count and the line-status byte, which come from the data path. The interrupt output is high while any cause bit is set.

All pins are plain control and status levels or single-cycle pulses. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, cause bits [4:0] and modem change bits [11:8] are 0 and `irq_o` is low.
- R2: Cause positions are: bit 0 line status (`line_evt_i`), bit 1 receive data (`rx_data_evt_i`), bit 2 character timeout (`rx_tmo_evt_i`), bit 3 transmit space (`tx_space_evt_i`), bit 4 modem status (any modem line change). A gated event sets its bit one clock later, and the bit stays set until it is cleared.
- R3: The enables are gates: `en_i[0]` for receive data and character timeout, `en_i[1]` for transmit space, `en_i[2]` for line status, `en_i[3]` for modem status. An event whose enable is 0 leaves its cause bit unchanged.
- R4: Several cause bits can be set in the same cycle, and each is kept independently of the others.
- R5: A write (`clr_we_i`) clears each cause bit n for which `clr_data_i[n]` is 1. Bits set to 0 leave their cause alone. `clr_data_i[7:5]` has no effect, and the fill bits [7:6] are never changed by the write.
- R6: An event that arrives in the same cycle as the clear of its bit wins, so the bit stays set. A modem line change during a modem clear also keeps that line's change bit.
- R7: `irq_o` is high exactly when at least one cause bit is set.
- R8: Modem field: bits 8..11 are change flags and bits 12..15 are registered levels, for lines 0..3 = CTS, DSR, RI, DCD. A change flag is set one clock after either edge of its line, whatever `en_i[3]` is. The first sample after reset sets up the reference and raises no flag.
- R9: The modem change flags are cleared by the same write that clears cause bit 4 (`clr_data_i[4]`=1).
- R10: Packing: bits [31:24] = `rx_fill_i[7:0]`, bits [7:6] = `rx_fill_i[9:8]`, bits [23:16] = `line_stat_i`, bit 5 = 0. These fields follow their inputs in the same cycle.
- R11: Dropping an enable does not clear a cause bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 4 | Source enables: 0 receive, 1 transmit, 2 line status, 3 modem |
| line_evt_i | input | 1 | Line-status event pulse |
| rx_data_evt_i | input | 1 | Receive-data event pulse |
| rx_tmo_evt_i | input | 1 | Character-timeout event pulse |
| tx_space_evt_i | input | 1 | Transmit-space event pulse |
| modem_lines_i | input | MODEM_N | Modem inputs: 0 CTS, 1 DSR, 2 RI, 3 DCD |
| line_stat_i | input | LSTAT_W | Line-status byte from the data path |
| rx_fill_i | input | 10 | Receive fill count |
| clr_we_i | input | 1 | Cause clear strobe |
| clr_data_i | input | 8 | Byte written to the low status byte |
| status_o | output | WORD_W | Packed status word |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: MODEM_N=4 and LSTAT_W=8, which give a 32-bit word. With these values it can reach every cause position, all four modem lines, the two fill high bits that share byte 0 with the causes, and full line-status and fill values. The behavioural model is updated on every clock, so the bench can cover enable gating, a clear and an event in the same cycle, ignored upper clear bits, and the reset priming of the modem tracker.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CAUSE_N    = 5;
  localparam int FILL_W     = 10;
  localparam int FILL_LO_W  = 8;
  localparam int FILL_HI_W  = FILL_W - FILL_LO_W;
  localparam int CLR_W      = 8;
  localparam int EN_W       = 4;

  localparam int CI_LINE    = 0;
  localparam int CI_RXDATA  = 1;
  localparam int CI_RXTMO   = 2;
  localparam int CI_TXSPACE = 3;
  localparam int CI_MODEM   = 4;

  localparam int EI_RX      = 0;
  localparam int EI_TX      = 1;
  localparam int EI_LINE    = 2;
  localparam int EI_MODEM   = 3;
endpackage

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R2, R6: a gated event always leaves the bit set
  a_r2_set_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R5: a clear with no event drops the bit
  a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  // R11: without a clear the bit is sticky
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/irq_modem_track.sv
module irq_modem_track #(
  parameter int LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  input  logic             clr_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] delta_o,
  output logic             change_o
);
  logic             primed_q;
  logic [LINES-1:0] level_q;
  logic [LINES-1:0] delta_q;
  logic [LINES-1:0] edge_w;

  assign edge_w = primed_q ? (lines_i ^ level_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      level_q  <= '0;
      delta_q  <= '0;
    end else begin
      primed_q <= 1'b1;
      level_q  <= lines_i;
      delta_q  <= (clr_i ? '0 : delta_q) | edge_w;
    end
  end

  assign level_o  = level_q;
  assign delta_o  = delta_q;
  assign change_o = |edge_w;

  // R8: any edge after priming raises the matching change flag
  a_r8_edge_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && (lines_i != level_q)) |=>
      ((delta_o & $past(lines_i ^ level_q)) == $past(lines_i ^ level_q)));
  // R9: a modem clear with quiet lines empties all flags
  a_r9_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (lines_i == level_q)) |=> (delta_o == '0));
  // R8: no flag appears on the priming sample
  a_r8_prime_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!primed_q) |=> (delta_o == '0));
endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
  import uart_irq_pkg::*;
#(
  parameter int MODEM_N = 4,
  parameter int LSTAT_W = 8,
  localparam int DLT_LSB = CLR_W,
  localparam int LVL_LSB = DLT_LSB + MODEM_N,
  localparam int LS_LSB  = LVL_LSB + MODEM_N,
  localparam int FLO_LSB = LS_LSB + LSTAT_W,
  localparam int WORD_W  = FLO_LSB + FILL_LO_W
) (
  input  logic [CAUSE_N-1:0] cause_i,
  input  logic [FILL_W-1:0]  fill_i,
  input  logic [MODEM_N-1:0] delta_i,
  input  logic [MODEM_N-1:0] level_i,
  input  logic [LSTAT_W-1:0] lstat_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int FHI_LSB = CLR_W - FILL_HI_W;
  localparam int GAP_W   = FHI_LSB - CAUSE_N;

  always_comb begin
    word_o = '0;
    word_o[CAUSE_N-1:0]                 = cause_i;
    word_o[FHI_LSB +: FILL_HI_W]        = fill_i[FILL_W-1:FILL_LO_W];
    word_o[DLT_LSB +: MODEM_N]          = delta_i;
    word_o[LVL_LSB +: MODEM_N]          = level_i;
    word_o[LS_LSB  +: LSTAT_W]          = lstat_i;
    word_o[FLO_LSB +: FILL_LO_W]        = fill_i[FILL_LO_W-1:0];
    if (GAP_W > 0) word_o[CAUSE_N]      = 1'b0;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int MODEM_N = 4,
  parameter int LSTAT_W = 8,
  localparam int WORD_W = CLR_W + 2 * MODEM_N + LSTAT_W + FILL_LO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EN_W-1:0]    en_i,
  input  logic               line_evt_i,
  input  logic               rx_data_evt_i,
  input  logic               rx_tmo_evt_i,
  input  logic               tx_space_evt_i,
  input  logic [MODEM_N-1:0] modem_lines_i,
  input  logic [LSTAT_W-1:0] line_stat_i,
  input  logic [FILL_W-1:0]  rx_fill_i,
  input  logic               clr_we_i,
  input  logic [CLR_W-1:0]   clr_data_i,
  output logic [WORD_W-1:0]  status_o,
  output logic               irq_o
);
  logic [CAUSE_N-1:0] set_vec;
  logic [CAUSE_N-1:0] clr_vec;
  logic [CAUSE_N-1:0] cause_q;
  logic [MODEM_N-1:0] mdm_level;
  logic [MODEM_N-1:0] mdm_delta;
  logic               mdm_change;

  irq_modem_track #(.LINES(MODEM_N)) u_modem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (modem_lines_i),
    .clr_i    (clr_vec[CI_MODEM]),
    .level_o  (mdm_level),
    .delta_o  (mdm_delta),
    .change_o (mdm_change)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[CI_LINE]    = line_evt_i     & en_i[EI_LINE];
    set_vec[CI_RXDATA]  = rx_data_evt_i  & en_i[EI_RX];
    set_vec[CI_RXTMO]   = rx_tmo_evt_i   & en_i[EI_RX];
    set_vec[CI_TXSPACE] = tx_space_evt_i & en_i[EI_TX];
    set_vec[CI_MODEM]   = mdm_change     & en_i[EI_MODEM];
  end

  assign clr_vec = clr_we_i ? clr_data_i[CAUSE_N-1:0] : '0;

  for (genvar g = 0; g < CAUSE_N; g++) begin : g_cause
    irq_cause_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .q_o    (cause_q[g])
    );
  end

  irq_status_pack #(.MODEM_N(MODEM_N), .LSTAT_W(LSTAT_W)) u_pack (
    .cause_i (cause_q),
    .fill_i  (rx_fill_i),
    .delta_i (mdm_delta),
    .level_i (mdm_level),
    .lstat_i (line_stat_i),
    .word_o  (status_o)
  );

  assign irq_o = |cause_q;

  // R3: with receive disabled, a clear receive-data cause stays clear
  a_r3_rx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i[EI_RX] && !cause_q[CI_RXDATA]) |=> !status_o[CI_RXDATA]);
  // R5: upper clear bits alone change no cause
  a_r5_upper_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && (clr_data_i[CLR_W-1:CAUSE_N] != '0) &&
     (clr_data_i[CAUSE_N-1:0] == '0) && (set_vec == '0))
      |=> (status_o[CAUSE_N-1:0] == $past(cause_q)));
  // R7: interrupt falls once all causes were cleared with no new event
  a_r7_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((cause_q & ~clr_data_i[CAUSE_N-1:0]) == '0) && (set_vec == '0))
      |=> !irq_o);
endmodule

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  en = 4'h0;
  logic        line_evt = 1'b0, rx_evt = 1'b0, tmo_evt = 1'b0, tx_evt = 1'b0;
  logic [3:0]  mdm = 4'h0;
  logic [7:0]  lstat = 8'h00;
  logic [9:0]  fill = 10'h000;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_data = 8'h00;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_irq_status i_uart_irq_status (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .line_evt_i(line_evt), .rx_data_evt_i(rx_evt), .rx_tmo_evt_i(tmo_evt),
    .tx_space_evt_i(tx_evt), .modem_lines_i(mdm), .line_stat_i(lstat),
    .rx_fill_i(fill), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .status_o(status), .irq_o(irq)
  );

  // behavioural reference
  logic [4:0] m_cause;
  logic [3:0] m_lvl, m_dlt, m_edge;
  logic [4:0] m_set, m_clr;
  bit         m_primed;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = 0; m_lvl = 0; m_dlt = 0; m_primed = 0;
    end else begin
      m_edge = m_primed ? (mdm ^ m_lvl) : 4'h0;
      m_set  = {en[3] && (m_edge != 0), tx_evt && en[1], tmo_evt && en[0],
                rx_evt && en[0], line_evt && en[2]};
      m_clr  = clr_we ? clr_data[4:0] : 5'h0;
      m_cause = (m_cause & ~m_clr) | m_set;
      m_dlt   = (m_clr[4] ? 4'h0 : m_dlt) | m_edge;
      m_lvl   = mdm;
      m_primed = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R4 R5 R6 R11 cause field", {27'b0, status[4:0]}, {27'b0, m_cause});
      chk("R8 R9 modem field", {24'b0, status[15:8]}, {24'b0, m_lvl, m_dlt});
      chk("R10 packing", {status[31:16], 8'b0, status[7:5], 5'b0},
          {fill[7:0], lstat, 8'b0, fill[9:8], 1'b0, 5'b0});
      chk("R7 irq", {31'b0, irq}, {31'b0, (m_cause != 0)});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulses_off();
    line_evt = 0; rx_evt = 0; tmo_evt = 0; tx_evt = 0; clr_we = 0; clr_data = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 causes", {27'b0, status[4:0]}, 32'h0);
    chk("R1 deltas", {28'b0, status[11:8]}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 all disabled
    en = 4'h0; line_evt = 1; rx_evt = 1; tmo_evt = 1; tx_evt = 1; tick();
    pulses_off();
    chk("R3 gated events", {27'b0, status[4:0]}, 32'h0);

    // R2 single source, R7 irq
    en = 4'hF; rx_evt = 1; tick(); pulses_off();
    chk("R2 rx data bit1", {27'b0, status[4:0]}, 32'h02);
    chk("R7 irq on", {31'b0, irq}, 32'h1);
    tick();
    chk("R2 sticky", {27'b0, status[4:0]}, 32'h02);

    // R4 several at once
    line_evt = 1; tmo_evt = 1; tx_evt = 1; tick(); pulses_off();
    chk("R4 multi", {27'b0, status[4:0]}, 32'h0F);

    // R5 clear bits 1,3 with upper bits set, fill high bits visible
    fill = 10'h2C5; clr_we = 1; clr_data = 8'hEA; tick(); pulses_off();
    chk("R5 clear", {27'b0, status[4:0]}, 32'h05);
    chk("R5 fill untouched", {30'b0, status[7:6]}, 32'h2);

    // R6 event and clear same cycle
    line_evt = 1; clr_we = 1; clr_data = 8'h01; tick(); pulses_off();
    chk("R6 event wins", {27'b0, status[4:0]}, 32'h05);

    // R11 drop enable keeps causes
    en = 4'h0; tick();
    chk("R11 kept", {27'b0, status[4:0]}, 32'h05);
    clr_we = 1; clr_data = 8'h1F; tick(); pulses_off();
    chk("R7 irq off", {31'b0, irq}, 32'h0);

    // R8 modem change with modem enable off
    mdm = 4'b0001; tick();
    chk("R8 cts delta", {24'b0, status[15:8]}, 32'h11);
    chk("R8 no cause", {31'b0, status[4]}, 32'h0);
    mdm = 4'b0000; tick();
    chk("R8 falling edge", {24'b0, status[15:8]}, 32'h01);
    // R9 clear deltas
    clr_we = 1; clr_data = 8'h10; tick(); pulses_off();
    chk("R9 deltas cleared", {28'b0, status[11:8]}, 32'h0);

    // R2 modem cause with enable
    en = 4'h8; mdm = 4'b0100; tick();
    chk("R2 modem cause", {27'b0, status[4:0]}, 32'h10);
    chk("R8 ri delta", {28'b0, status[11:8]}, 32'h4);
    // R6/R9 clear while dsr toggles
    mdm = 4'b0110; clr_we = 1; clr_data = 8'h10; tick(); pulses_off();
    chk("R6 modem change wins", {27'b0, status[4:0]}, 32'h10);
    chk("R9 only new delta kept", {28'b0, status[11:8]}, 32'h2);

    // R10 packing patterns
    lstat = 8'hA5; fill = 10'h13C; #1;
    chk("R10 word", {status[31:16], status[7:5]}, {8'h3C, 8'hA5, 2'b01, 1'b0});
    lstat = 8'h5A; fill = 10'h3FF; #1;
    chk("R10 word max", {status[31:16], status[7:5]}, {8'hFF, 8'h5A, 2'b11, 1'b0});

    // R8 priming after reset with lines high
    rst_n = 0; mdm = 4'b1011; tick(); tick();
    rst_n = 1; tick();
    chk("R8 prime no delta", {24'b0, status[15:8]}, 32'hB0);
    chk("R1 reset causes", {27'b0, status[4:0]}, 32'h0);
    mdm = 4'b0011; en = 4'hF; tick();
    chk("R8 dcd delta", {24'b0, status[15:8]}, 32'h38);

    // mixed traffic compared by model
    for (int i = 0; i < 200; i++) begin
      en = 4'(i * 7); line_evt = i[0]; rx_evt = i[1]; tmo_evt = i[2] ^ i[0];
      tx_evt = i[3]; mdm = 4'(i / 3); clr_we = i[2]; clr_data = 8'(i * 13);
      lstat = 8'(i * 5); fill = 10'(i * 37);
      tick();
    end
    pulses_off(); tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule